// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer with Buffered Byte Access

This block is a 16-bit up-counter for a microcontroller-style peripheral. Each step comes either from an internal tick, one pulse per instruction cycle, or from rising edges of an external clock pin. The chosen source passes through a prescaler that divides by 1, 2, 4 or 8. The external pin can be passed through a two-flop synchronizer, which gives the synchronous counter mode. It can also skip the synchronizer, which gives the asynchronous counter mode. In both modes a previous-sample comparison turns each rising edge into exactly one tick.

A run input gates the counting. A compare-match pulse from a neighbouring block clears the whole count. Wrapping from 0xFFFF to 0x0000 sets a sticky overflow flag, which stays set until a clear strobe arrives.

Software reaches the count over a byte-wide bus with two addresses. In wide mode the high byte goes through a buffer, so that 16-bit reads and writes are coherent. Reading the low byte snapshots the live high byte into the buffer. Writing the low byte loads the buffer and the written byte into the counter in the same cycle.

Top module: `pscl_timer16`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0, and the high-byte buffer is 0x00 (seen as bus_rdata at address 1 in wide mode).
- R2: With src_ext=0 and run=1 at a divide ratio of 1, the count rises by one for each clock cycle in which cyc_tick is high. With src_ext=1, cyc_tick has no effect.
- R3: div_sel 0, 1, 2 and 3 give one count step per 1, 2, 4 and 8 source ticks. Any bus write that changes the counter, and any change of div_sel, restarts the prescaler from zero.
- R4: While run=0, source ticks are ignored and the count holds.
- R5: A step from 0xFFFF wraps the count to 0x0000 and sets ovf_flag. The flag stays set until ovf_clr is high for a cycle. If a wrap and ovf_clr fall in the same cycle, the flag ends up set.
- R6: evt_clr high at a clock edge makes the count 0x0000 after that edge, overriding a bus write and a step in the same cycle.
- R7: With src_ext=1 and sync_en=1, each rising edge of ext_clk gives exactly one step. The step is visible after the third rising clk edge that follows the ext_clk rise. A held level and a falling edge give none.
- R8: With src_ext=1 and sync_en=0, the synchronizer is bypassed. The step for an ext_clk rise is visible after the first rising clk edge that follows it, and there is still exactly one step per rising edge.
- R9: Bus address 0 is the low byte and address 1 is the high byte, and bus_rdata follows bus_addr combinationally. In wide mode (wide_mode=1), address 1 reads and writes only the buffer. A bus_rd at address 0 copies the live high byte into the buffer. A write at address 0 loads {buffer, bus_wdata} into the counter.
- R10: With wide_mode=0, address 1 reads and writes the live high byte, and a write at address 0 changes only the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | Internal instruction-cycle tick, one cycle wide |
| ext_clk | input | 1 | External count clock, asynchronous to clk |
| src_ext | input | 1 | Source select: 0 internal tick, 1 external clock |
| sync_en | input | 1 | 1 synchronizes ext_clk before edge detection |
| div_sel | input | 2 | Prescale select: divide by 2^div_sel |
| run | input | 1 | Counting enable |
| evt_clr | input | 1 | Compare-match clear of the whole count |
| wide_mode | input | 1 | 1 selects buffered 16-bit access |
| bus_addr | input | 1 | 0 low byte, 1 high byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the buffer snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can meet in the same clock cycle. A wrap can coincide with the flag clear strobe, and the compare-match clear can coincide with a counting step or a bus write. The bench loads 0xFFFF and then raises cyc_tick and ovf_clr together; the flag must read 1 afterwards. It also raises evt_clr in the same cycle as a tick, and in the same cycle as a low-byte write; the count must read 0x0000 afterwards. In both cases the result is judged by reading the count back through the bus once the colliding cycle is over.

// File: rtl/pscl_timer_pkg.sv
// Package: shared constants and helpers for the prescaled timer.
// Assumes the byte bus has two addresses: low byte and high byte.
package pscl_timer_pkg;

    // Byte lane selector on the register bus.
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Terminal value of the prescaler counter for a given select code.
    function automatic logic [7:0] div_limit(input logic [2:0] sel);
        return 8'((9'd1 << sel) - 9'd1);
    endfunction

endpackage

// File: rtl/pscl_edge_front.sv
// Module: external clock front end.
// Brings ext_clk through an optional synchronizer chain and turns each
// rising edge into a one-cycle pulse. Assumes SYNC_STAGES >= 2.
module pscl_edge_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic sync_en,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   sample;
    logic                   prev_q;

    // Synchronizer chain, one flop per stage.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            // First stage samples the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= ext_clk;
            end
        end else begin : g_next
            // Later stages follow the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // Pick the synchronized or the raw level.
    always_comb sample = sync_en ? chain_q[SYNC_STAGES-1] : ext_clk;

    // Remember the last sampled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sample;
    end

    // A rising edge is a high sample after a low one.
    always_comb rise = sample & ~prev_q;

endmodule

// File: rtl/pscl_divider.sv
// Module: tick prescaler.
// Passes one of every 2^div_sel input ticks. Restarts from zero on
// restart or when div_sel changes; a tick in such a cycle is dropped.
module pscl_divider #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             restart,
    output logic             step
);
    import pscl_timer_pkg::*;

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [SEL_W-1:0] sel_q;
    logic             flush;

    // Terminal count for the current ratio.
    always_comb lim = CNT_W'(div_limit(3'(div_sel)));

    // Restart on request or on a new ratio.
    always_comb flush = restart | (div_sel != sel_q);

    // Emit a step when the terminal count is reached.
    always_comb step = tick & ~flush & (cnt_q == lim);

    // Track the ratio in use.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= div_sel;
    end

    // Prescaler count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (flush)  cnt_q <= '0;
        else if (tick)   cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/pscl_count_core.sv
// Module: counter register, high-byte buffer, overflow flag and bus mux.
// Priority on the count: event clear, then bus write, then step.
// Assumes WIDTH = 2 * BYTE_W.
module pscl_count_core #(
    parameter int WIDTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              evt_clr,
    input  logic              wide_mode,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    output logic              count_wr,
    output logic [WIDTH-1:0]  count,
    output logic [BYTE_W-1:0] hbuf
);
    import pscl_timer_pkg::*;

    localparam int HI_W = WIDTH - BYTE_W;

    logic [WIDTH-1:0]  count_q;
    logic [BYTE_W-1:0] hbuf_q;
    logic              ovf_q;
    logic              wrap;
    logic              sel_lo;

    always_comb sel_lo = (lane_e'(bus_addr) == LANE_LO);

    // A write touches the counter unless it only fills the buffer.
    always_comb count_wr = bus_wr & (sel_lo | ~wide_mode);

    // Wrap from all ones on a real step.
    always_comb wrap = step & ~evt_clr & ~count_wr & (&count_q);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (evt_clr) count_q <= '0;
        else if (count_wr) begin
            if (sel_lo)
                count_q <= wide_mode ? {hbuf_q, bus_wdata}
                                     : {count_q[WIDTH-1:BYTE_W], bus_wdata};
            else
                count_q <= {HI_W'(bus_wdata), count_q[BYTE_W-1:0]};
        end
        else if (step)    count_q <= count_q + 1'b1;
    end

    // High-byte buffer: filled by a wide high write or a wide low read.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hbuf_q <= '0;
        else if (bus_wr && wide_mode && !sel_lo) hbuf_q <= bus_wdata;
        else if (bus_rd && wide_mode && sel_lo)  hbuf_q <= BYTE_W'(count_q[WIDTH-1:BYTE_W]);
    end

    // Sticky overflow flag; a wrap beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    // Read mux.
    always_comb begin
        if (sel_lo)         bus_rdata = count_q[BYTE_W-1:0];
        else if (wide_mode) bus_rdata = hbuf_q;
        else                bus_rdata = BYTE_W'(count_q[WIDTH-1:BYTE_W]);
    end

    always_comb ovf_flag = ovf_q;
    always_comb count    = count_q;
    always_comb hbuf     = hbuf_q;

endmodule

// File: rtl/pscl_timer16.sv
// Module: top of the prescaled timer.
// Selects the tick source, gates it with run, divides it and counts.
// Assumes cyc_tick is a one-cycle pulse synchronous to clk.
module pscl_timer16 #(
    parameter int WIDTH       = 16,
    parameter int BYTE_W      = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              ext_clk,
    input  logic              src_ext,
    input  logic              sync_en,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              run,
    input  logic              evt_clr,
    input  logic              wide_mode,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ovf_clr,
    output logic              ovf_flag
);
    logic              ext_rise;
    logic              src_tick;
    logic              inc_w;
    logic              count_wr;
    logic [WIDTH-1:0]  cnt_live;
    logic [BYTE_W-1:0] hbuf_live;

    pscl_edge_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .sync_en (sync_en),
        .rise    (ext_rise)
    );

    // Source select gated by run.
    always_comb src_tick = run & (src_ext ? ext_rise : cyc_tick);

    pscl_divider #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (src_tick),
        .div_sel (div_sel),
        .restart (count_wr),
        .step    (inc_w)
    );

    pscl_count_core #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (inc_w),
        .evt_clr   (evt_clr),
        .wide_mode (wide_mode),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ovf_clr   (ovf_clr),
        .ovf_flag  (ovf_flag),
        .count_wr  (count_wr),
        .count     (cnt_live),
        .hbuf      (hbuf_live)
    );

endmodule

// File: rtl/pscl_timer16_chk.sv
// Checker: temporal properties of the timer, bound to the top module.
// Assumes the default 16-bit count and 8-bit buffer.
module pscl_timer16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        evt_clr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_addr,
    input logic        wide_mode,
    input logic        ovf_clr,
    input logic        ovf_flag,
    input logic        inc_w,
    input logic [15:0] count_q,
    input logic [7:0]  hbuf_q
);
    // R4: a stopped counter with no clear or write holds.
    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !evt_clr && !bus_wr) |=> $stable(count_q));

    // R4: no step reaches the counter while stopped.
    a_r4_no_step_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !inc_w);

    // R6: event clear empties the count.
    a_r6_event_clear: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |=> (count_q == 16'h0000));

    // R5: a step from all ones wraps and raises the flag.
    a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_w && count_q == 16'hFFFF && !evt_clr && !bus_wr) |=> (ovf_flag && count_q == 16'h0000));

    // R5: the flag stays until cleared.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R2: an undisturbed step adds one.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_w && !evt_clr && !bus_wr && count_q != 16'hFFFF) |=> (count_q == $past(count_q) + 16'd1));

    // R9: a wide low-byte read snapshots the live high byte.
    a_r9_buffer_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && wide_mode && !bus_addr && !bus_wr) |=> (hbuf_q == $past(count_q[15:8])));

endmodule

bind pscl_timer16 pscl_timer16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .evt_clr   (evt_clr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .wide_mode (wide_mode),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag),
    .inc_w     (inc_w),
    .count_q   (cnt_live),
    .hbuf_q    (hbuf_live)
);

// File: tb/pscl_timer16_tb.sv
// Directed bench for the prescaled timer. Inputs change on falling edges.
module pscl_timer16_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0, ext_clk = 1'b0, src_ext = 1'b0, sync_en = 1'b1;
    logic [1:0] div_sel = 2'd0;
    logic       run = 1'b0, evt_clr = 1'b0, wide_mode = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;
    int         n_tests = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pscl_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_clk(ext_clk),
        .src_ext(src_ext), .sync_en(sync_en), .div_sel(div_sel), .run(run),
        .evt_clr(evt_clr), .wide_mode(wide_mode), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // Reads the live count at the current falling edge, no clock used.
    task automatic get_count(output logic [15:0] v);
        logic w;
        w = wide_mode; wide_mode = 1'b0;
        bus_addr = 1'b0; #1 v[7:0] = bus_rdata;
        bus_addr = 1'b1; #1 v[15:8] = bus_rdata;
        wide_mode = w;
    endtask

    task automatic set_count(input logic [15:0] v);
        logic w;
        w = wide_mode; wide_mode = 1'b0;
        wr(1'b0, v[7:0]); wr(1'b1, v[15:8]);
        wide_mode = w;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); cyc_tick = 1'b1; end
        @(negedge clk); cyc_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] c;
        get_count(c);
        check("R1 count after reset", c, 16'h0000);
        check("R1 flag after reset", ovf_flag, 1'b0);
        wide_mode = 1'b1; bus_addr = 1'b1; #1;
        check("R1 buffer after reset", bus_rdata, 8'h00);
        wide_mode = 1'b0;
    endtask

    task automatic t_internal;
        logic [15:0] c;
        run = 1'b1; src_ext = 1'b0; div_sel = 2'd0;
        set_count(16'h0000); ticks(5); get_count(c);
        check("R2 five internal ticks", c, 16'd5);
        run = 1'b0; ticks(4); get_count(c);
        check("R4 ticks ignored while stopped", c, 16'd5);
        run = 1'b1; src_ext = 1'b1; ticks(4); get_count(c);
        check("R2 internal tick ignored on external source", c, 16'd5);
        src_ext = 1'b0;
    endtask

    task automatic t_prescale;
        logic [15:0] c;
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d); set_count(16'h0000); ticks(16); get_count(c);
            check($sformatf("R3 ratio code %0d", d), c, 16'(16 >> d));
        end
        div_sel = 2'd3; set_count(16'h0000); ticks(5);
        set_count(16'h0000); ticks(7); get_count(c);
        check("R3 write restarts prescaler", c, 16'd0);
        ticks(1); get_count(c);
        check("R3 eighth tick after restart", c, 16'd1);
        set_count(16'h0000); ticks(5);
        div_sel = 2'd2; idle(1); ticks(4); get_count(c);
        check("R3 ratio change restarts prescaler", c, 16'd1);
        div_sel = 2'd0; idle(1);
    endtask

    task automatic t_overflow;
        logic [15:0] c;
        set_count(16'hFFFF);
        check("R5 write does not set flag", ovf_flag, 1'b0);
        ticks(1); get_count(c);
        check("R5 wrap to zero", c, 16'h0000);
        check("R5 flag set on wrap", ovf_flag, 1'b1);
        ticks(3);
        check("R5 flag sticky", ovf_flag, 1'b1);
        @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R5 flag cleared", ovf_flag, 1'b0);
        set_count(16'hFFFF);
        @(negedge clk); cyc_tick = 1'b1; ovf_clr = 1'b1;
        @(negedge clk); cyc_tick = 1'b0; ovf_clr = 1'b0;
        check("R5 wrap beats clear", ovf_flag, 1'b1);
        @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    endtask

    task automatic t_event;
        logic [15:0] c;
        set_count(16'h1234);
        @(negedge clk); evt_clr = 1'b1; cyc_tick = 1'b1;
        @(negedge clk); evt_clr = 1'b0; cyc_tick = 1'b0;
        get_count(c);
        check("R6 clear beats step", c, 16'h0000);
        set_count(16'h4321);
        @(negedge clk); evt_clr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h55; bus_wr = 1'b1;
        @(negedge clk); evt_clr = 1'b0; bus_wr = 1'b0;
        get_count(c);
        check("R6 clear beats write", c, 16'h0000);
    endtask

    task automatic t_sync;
        logic [15:0] c;
        src_ext = 1'b1; sync_en = 1'b1; ext_clk = 1'b0; idle(4);
        set_count(16'h0000);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); get_count(c); check("R7 no step after one edge", c, 16'd0);
        @(negedge clk); get_count(c); check("R7 no step after two edges", c, 16'd0);
        @(negedge clk); get_count(c); check("R7 step after three edges", c, 16'd1);
        idle(3); ext_clk = 1'b0; idle(4); get_count(c);
        check("R7 level and fall give no step", c, 16'd1);
        for (int p = 0; p < 3; p++) begin
            ext_clk = 1'b1; idle(4); ext_clk = 1'b0; idle(4);
        end
        get_count(c);
        check("R7 one step per rise", c, 16'd4);
    endtask

    task automatic t_async;
        logic [15:0] c;
        sync_en = 1'b0; idle(3); set_count(16'h0000);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); get_count(c); check("R8 step after first edge", c, 16'd1);
        idle(3); get_count(c); check("R8 held level no extra step", c, 16'd1);
        ext_clk = 1'b0; idle(2); ext_clk = 1'b1; idle(2); get_count(c);
        check("R8 second rise", c, 16'd2);
        ext_clk = 1'b0; idle(2); src_ext = 1'b0; sync_en = 1'b1;
    endtask

    task automatic t_wide;
        logic [15:0] c;
        logic [7:0]  v;
        run = 1'b0; set_count(16'h00AA); wide_mode = 1'b1;
        wr(1'b1, 8'h34); rd(1'b1, v);
        check("R9 high address reads buffer", v, 8'h34);
        get_count(c);
        check("R9 buffer write leaves counter", c, 16'h00AA);
        wr(1'b0, 8'h56); get_count(c);
        check("R9 low write loads buffer and byte", c, 16'h3456);
        run = 1'b1; wide_mode = 1'b0; set_count(16'h12FF); wide_mode = 1'b1;
        rd(1'b0, v);
        check("R9 low read live byte", v, 8'hFF);
        ticks(1); get_count(c);
        check("R9 counter moved on", c, 16'h1300);
        rd(1'b1, v);
        check("R9 buffered high byte coherent", v, 8'h12);
        wide_mode = 1'b0;
    endtask

    task automatic t_narrow;
        logic [15:0] c;
        logic [7:0]  v;
        run = 1'b0; wide_mode = 1'b0; set_count(16'h0000);
        wr(1'b1, 8'h9A); get_count(c);
        check("R10 direct high write", c, 16'h9A00);
        wr(1'b0, 8'h01); get_count(c);
        check("R10 low write keeps high", c, 16'h9A01);
        rd(1'b1, v);
        check("R10 direct high read", v, 8'h9A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_internal;
        t_prescale;
        t_overflow;
        t_event;
        t_sync;
        t_async;
        t_wide;
        t_narrow;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule